// File: doc/BRIEF.md
# Power-On and Pushbutton Reset Generator

This block produces the active-low system reset for a small processor board. From configuration onward it holds reset asserted for a fixed interval, then releases it. It asserts reset again for one full interval after each press of a reset pushbutton, and for as long as an external supply comparator reports undervoltage. The pushbutton and the undervoltage flag are asynchronous to the clock. Both pass through a synchronizer before they reach a single shared interval counter.

The counter reloads to the full interval on every clock in which either source is seen active, and counts down otherwise. Reset is released only when the count reaches zero. So the interval always runs from the moment the last active condition disappears. Contact bounce, a held button or a lingering undervoltage therefore stretch one reset pulse instead of splitting it into several short ones.

The interval length in clocks is a parameter. By default it is derived from the clock frequency and a length in milliseconds: 150 ms at 4 MHz gives 600000 cycles. A simulation can override it with a short value.

Top module: `sysreset_ctrl`

## Requirements
- R1: From time zero `rst_n_o` is 0 and stays 0 until rising clock edge number PULSE_CYCLES. After that edge it is 1, provided no source is active.
- R2: The button is active when `btn_n_i` is 0. If the button is first sampled active at edge k, `rst_n_o` is 0 after edge k+SYNC_STAGES.
- R3: Let k be the last edge at which any source is sampled active. `rst_n_o` stays 0 through edge k+SYNC_STAGES+PULSE_CYCLES-1 and becomes 1 after edge k+SYNC_STAGES+PULSE_CYCLES. A button held for many cycles keeps reset low for the whole hold.
- R4: Button activity made of bursts separated by gaps shorter than PULSE_CYCLES produces one uninterrupted low interval on `rst_n_o`, with exactly one rising edge.
- R5: The undervoltage flag is active when `brownout_i` is 1. `rst_n_o` is 0 for the whole time the flag is active, and for PULSE_CYCLES edges after the flag's last active sample has passed the synchronizer.
- R6: A button press seen at a single clock edge produces a full-length pulse of PULSE_CYCLES cycles.
- R7: While no source is active and the interval has expired, `rst_n_o` stays 1 on every cycle.
- R8: When button and undervoltage activity overlap, the interval is timed from whichever source was sampled active last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| btn_n_i | input | 1 | Asynchronous reset pushbutton, 0 = pressed |
| brownout_i | input | 1 | Asynchronous undervoltage flag from a comparator, 1 = supply low |
| rst_n_o | output | 1 | Registered system reset, 0 = asserted |

## Verification
Two kinds of fault in the internal count show up at `rst_n_o`. A count that fails to reload makes reset rise early, fewer than PULSE_CYCLES cycles after an event. A count that skips or sticks makes the release come late or never. A fault in the synchronizer depth moves every falling and rising edge by whole cycles. The bench compares the output against an edge-timed reference on every clock, so any of these faults appears within one interval of the event that exposes it. Bounce patterns and overlapping sources exercise the reload path while the count is partly expired.

// File: rtl/sysreset_pkg.sv
package sysreset_pkg;
   // Bits needed to hold the values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/sysreset_sync.sv
module sysreset_sync #(
   parameter int unsigned     WIDTH  = 2,
   parameter int unsigned     STAGES = 2,
   parameter logic [WIDTH-1:0] INIT  = '0
) (
   input  logic             clk_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sysreset_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sysreset_sync: WIDTH must be at least 1");
      end
   endgenerate

   // Stage 0 is the capture flop; the top stage feeds the logic.
   logic [STAGES-1:0][WIDTH-1:0] stage_q = {STAGES{INIT}};

   always_ff @(posedge clk_i) begin
      stage_q <= {stage_q[STAGES-2:0], async_i};
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sysreset_hold.sv
module sysreset_hold #(
   parameter int unsigned PULSE_CYCLES = 600000,
   parameter int unsigned CW           = sysreset_pkg::cnt_width(PULSE_CYCLES)
) (
   input  logic          clk_i,
   input  logic          trig_i,
   output logic [CW-1:0] cnt_o,
   output logic          rst_n_o
);
   localparam logic [CW-1:0] FULL = CW'(PULSE_CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   generate
      if (PULSE_CYCLES < 2) begin : g_bad_pulse
         $error("sysreset_hold: PULSE_CYCLES must be at least 2");
      end
      if (CW < sysreset_pkg::cnt_width(PULSE_CYCLES)) begin : g_bad_cw
         $error("sysreset_hold: CW too narrow for PULSE_CYCLES");
      end
   endgenerate

   // Full count at configuration: reset is asserted from time zero.
   logic [CW-1:0] cnt_q   = FULL;
   logic          rst_n_q = 1'b0;
   logic [CW-1:0] cnt_d;

   always_comb begin
      if (trig_i)
         cnt_d = FULL;
      else if (cnt_q != '0)
         cnt_d = cnt_q - ONE;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk_i) begin
      cnt_q   <= cnt_d;
      rst_n_q <= (cnt_d == '0);
   end

   assign cnt_o   = cnt_q;
   assign rst_n_o = rst_n_q;
endmodule

// File: rtl/sysreset_ctrl.sv
module sysreset_ctrl #(
   parameter int unsigned CLK_HZ       = 4_000_000,
   parameter int unsigned PULSE_MS     = 150,
   parameter int unsigned PULSE_CYCLES = (CLK_HZ / 1000) * PULSE_MS,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic btn_n_i,
   input  logic brownout_i,
   output logic rst_n_o
);
   localparam int unsigned CNT_W = sysreset_pkg::cnt_width(PULSE_CYCLES);
   // Bit 0: button (idle 1), bit 1: undervoltage flag (idle 0)
   localparam logic [1:0] SYNC_INIT = 2'b01;

   generate
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("sysreset_ctrl: CLK_HZ must be at least 1000");
      end
   endgenerate

   logic [1:0]       src_sync;
   logic             trig;
   logic [CNT_W-1:0] hold_cnt;

   sysreset_sync #(
      .WIDTH (2),
      .STAGES(SYNC_STAGES),
      .INIT  (SYNC_INIT)
   ) sync_i (
      .clk_i  (clk_i),
      .async_i({brownout_i, btn_n_i}),
      .sync_o (src_sync)
   );

   assign trig = src_sync[1] | ~src_sync[0];

   sysreset_hold #(
      .PULSE_CYCLES(PULSE_CYCLES),
      .CW          (CNT_W)
   ) hold_i (
      .clk_i  (clk_i),
      .trig_i (trig),
      .cnt_o  (hold_cnt),
      .rst_n_o(rst_n_o)
   );
endmodule

// File: rtl/sysreset_chk.sv
module sysreset_chk #(
   parameter int unsigned PULSE_CYCLES = 600000,
   parameter int unsigned CW           = 20
) (
   input logic          clk_i,
   input logic          trig_i,
   input logic [CW-1:0] cnt_i,
   input logic          rst_n_i
);
   localparam logic [CW-1:0] FULL = CW'(PULSE_CYCLES);

   logic armed = 1'b0;
   always_ff @(posedge clk_i) armed <= 1'b1;

   // R2 / R5: an active source asserts reset on the next edge
   a_r2_source_forces_low: assert property (@(posedge clk_i) disable iff (!armed)
      trig_i |=> !rst_n_i);

   // R3: every active sample restarts the full interval
   a_r3_reload_full: assert property (@(posedge clk_i) disable iff (!armed)
      trig_i |=> cnt_i == FULL);

   // R3: with sources idle the interval shrinks by one per cycle
   a_r3_steady_countdown: assert property (@(posedge clk_i) disable iff (!armed)
      (!trig_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - CW'(1));

   // R1: the count never exceeds the interval
   a_r1_count_bounded: assert property (@(posedge clk_i) disable iff (!armed)
      cnt_i <= FULL);

   // R4: release only once the interval expired with no source active
   a_r4_release_at_zero: assert property (@(posedge clk_i) disable iff (!armed)
      $rose(rst_n_i) |-> (cnt_i == '0 && $past(!trig_i)));

   // R7: released reset stays released while sources stay idle
   a_r7_stays_high: assert property (@(posedge clk_i) disable iff (!armed)
      (rst_n_i && !trig_i) |=> rst_n_i);
endmodule

bind sysreset_ctrl sysreset_chk #(
   .PULSE_CYCLES(PULSE_CYCLES),
   .CW          (CNT_W)
) chk_i (
   .clk_i  (clk_i),
   .trig_i (trig),
   .cnt_i  (hold_cnt),
   .rst_n_i(rst_n_o)
);

// File: tb/sysreset_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysreset_ctrl_tb_top;
   localparam int unsigned P    = 40;
   localparam int unsigned SYNC = 2;

   logic clk = 1'b0;
   logic btn_n = 1'b1;
   logic brownout = 1'b0;
   logic rst_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #4 clk = ~clk;   // 125 MHz

   sysreset_ctrl #(.PULSE_CYCLES(P), .SYNC_STAGES(SYNC)) dut_i (
      .clk_i     (clk),
      .btn_n_i   (btn_n),
      .brownout_i(brownout),
      .rst_n_o   (rst_n)
   );

   // Reference: track the edge until which reset must stay low
   int edge_n = 0;
   int low_until = P;
   bit act_q[$];

   always @(posedge clk) begin
      edge_n++;
      act_q.push_back(!btn_n || brownout);
      if (act_q.size() > SYNC) begin
         if (act_q.pop_front()) low_until = edge_n + P;
      end
   end

   // Compare on every falling edge, count rising edges of the output
   logic prev_rst = 1'b0;
   int   rises = 0;
   always @(negedge clk) begin
      logic exp_v;
      exp_v = (edge_n >= low_until);
      checks++;
      if (rst_n !== exp_v) begin
         errors++;
         $display("FAIL %s: edge %0d rst_n_o=%b expected %b", phase, edge_n, rst_n, exp_v);
      end
      if (rst_n && !prev_rst) rises++;
      prev_rst = rst_n;
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_rises(input string req, input int exp_n);
      checks++;
      if (rises != exp_n) begin
         errors++;
         $display("FAIL %s: rising edges %0d expected %0d", req, rises, exp_n);
      end
      rises = 0;
   endtask

   initial begin
      #1;
      checks++;   // R1: reset asserted before the first edge
      if (rst_n !== 1'b0) begin
         errors++;
         $display("FAIL R1: rst_n_o=%b expected 0 at time zero", rst_n);
      end
      idle(P + 20);
      check_rises("R1", 1);

      phase = "R6";   // single-cycle press
      btn_n = 1'b0; idle(1); btn_n = 1'b1;
      idle(P + 20);
      check_rises("R6", 1);

      phase = "R3";   // long hold
      btn_n = 1'b0; idle(3 * P); btn_n = 1'b1;
      idle(P + 20);
      check_rises("R3", 1);

      phase = "R4";   // bouncing contact
      for (int i = 0; i < 6; i++) begin
         btn_n = 1'b0; idle(2 + i);
         btn_n = 1'b1; idle(P - 10 + i);
      end
      idle(P + 20);
      check_rises("R4", 1);

      phase = "R5";   // undervoltage
      brownout = 1'b1; idle(2 * P); brownout = 1'b0;
      idle(P + 20);
      check_rises("R5", 1);

      phase = "R8";   // overlap, button ends last, then flag ends last
      brownout = 1'b1; idle(10); btn_n = 1'b0; idle(10);
      brownout = 1'b0; idle(15); btn_n = 1'b1;
      idle(P + 20);
      btn_n = 1'b0; idle(5); brownout = 1'b1; idle(5);
      btn_n = 1'b1; idle(25); brownout = 1'b0;
      idle(P + 20);
      check_rises("R8", 2);

      phase = "R2";   // press during an interval, released before expiry
      btn_n = 1'b0; idle(2); btn_n = 1'b1; idle(P / 2);
      btn_n = 1'b0; idle(1); btn_n = 1'b1;
      idle(P + 20);
      check_rises("R2", 1);

      phase = "R7";   // long quiet stretch
      idle(4 * P);
      check_rises("R7", 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule